// File: doc/BRIEF.md
# Microcoded Two-Bus Stack Datapath

This block is the register and arithmetic half of a small stack-machine processor. A sequencer outside the block presents one control word every clock cycle. One field of that word picks which register drives the B bus. A second field configures the ALU and the shifter that follows it. A one-hot mask chooses which registers capture the result from the C bus at the end of the cycle. The H register always feeds the ALU's A input. The block hands zero and negative flags back to the sequencer for branching.

Two memory ports leave the block. A 32-bit word port is addressed by MAR and reads and writes through MDR. A read-only byte fetch port is addressed by PC. It returns the whole word that holds that byte, and the block selects the byte lane itself, little-endian, into MBR. MBR can drive the B bus sign-extended or zero-extended. Memory requests are registered at the block's edge, and read data lands two cycles after the request.

Top module: `twoBusDatapath`

## Requirements
- R1: While reset is held, every register (MAR, MDR, PC, MBR, SP, LV, CPP, TOS, OPC, H), both flags and all three memory strobes are zero.
- R2: The ALU field, bit 7 down to bit 0, is: left-shift-8, arithmetic-right-1, F0, F1, enable A, enable B, invert A, increment. A is H gated by enable A and then complemented if invert A is set. B is the B bus gated by enable B. {F0,F1} selects the function: 00 gives A AND B, 01 gives A OR B, 10 gives NOT B, 11 gives A+B+increment. As a result, 0x14 passes B, 0x18 passes A, 0x10 gives zero, 0x3F gives B−A and 0x3B gives −A.
- R3: Bit 7 shifts the ALU result left by 8 and bit 6 shifts it arithmetically right by 1 before it reaches the C bus. With both bits set, the left shift is applied first.
- R4: B-select codes are: 0 MDR, 1 PC, 2 MBR sign-extended, 3 MBR zero-extended, 4 SP, 5 LV, 6 CPP, 7 TOS, 8 OPC. Codes 9 to 15 drive zero.
- R5: C-mask bits, bit 0 up to bit 8, write MAR, MDR, PC, SP, LV, CPP, TOS, OPC and H. Every set bit is written with the shifter output at the end of the cycle. An all-zero mask changes no register.
- R6: The zero and negative flags are taken from the ALU result before the shifter and are registered. They reflect the control word of the previous cycle.
- R7: A word read requested in cycle t raises wordRdEn in cycle t+1, with wordAddr equal to MAR as it stands in t+1. MDR takes wordRdData at the end of t+1. In that cycle the memory data has priority over a C-bus write to MDR.
- R8: A word write requested in cycle t raises wordWrEn in cycle t+1, with wordAddr and wordWrData equal to MAR and MDR as they stand in t+1, after the writes of cycle t.
- R9: A fetch requested in cycle t raises fetchEn in cycle t+1, with fetchAddr equal to PC. At the end of t+1, MBR takes byte lane PC[1:0] of fetchWord, where lane 0 is bits 7:0.
- R10: On the B bus, MBR sign-extended copies MBR bit 7 into bits 31:8, and MBR zero-extended clears bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aluCtl | input | 8 | ALU and shifter control field |
| bSel | input | 4 | B-bus source code |
| cMask | input | 9 | One-hot-per-register C-bus write mask |
| rdReq | input | 1 | Word read request |
| wrReq | input | 1 | Word write request |
| fetchReq | input | 1 | Byte fetch request |
| wordAddr | output | 32 | Word address (MAR) |
| wordWrData | output | 32 | Write data (MDR) |
| wordRdEn | output | 1 | Word read strobe |
| wordWrEn | output | 1 | Word write strobe |
| wordRdData | input | 32 | Word read data, sampled while wordRdEn is high |
| fetchAddr | output | 32 | Byte fetch address (PC) |
| fetchEn | output | 1 | Fetch strobe |
| fetchWord | input | 32 | Word containing the fetched byte |
| cBus | output | 32 | Shifter output for the current control word |
| zFlag | output | 1 | Registered zero flag |
| nFlag | output | 1 | Registered negative flag |

## Verification
cBus is combinational, so it is compared in the same cycle as its control word, just before the clock edge. The flags and every register visible at a port are due one edge later. Memory strobes appear one cycle after a request. MDR and MBR, seen through the B bus on cBus, change two cycles after the request. The bench keeps a behavioural model that steps once per edge under the same control words. It compares combinational results before the edge and registered results at the following falling edge, so each value is checked exactly in the cycle it is due.

// File: rtl/twoBusPkg.sv
package twoBusPkg;
  // ALU control field bit positions
  localparam int AluSll8 = 7;
  localparam int AluSra1 = 6;
  localparam int AluF0   = 5;
  localparam int AluF1   = 4;
  localparam int AluEnA  = 3;
  localparam int AluEnB  = 2;
  localparam int AluInvA = 1;
  localparam int AluInc  = 0;

  // B bus source codes
  localparam logic [3:0] BMdr  = 4'd0;
  localparam logic [3:0] BPc   = 4'd1;
  localparam logic [3:0] BMbrS = 4'd2;
  localparam logic [3:0] BMbrU = 4'd3;
  localparam logic [3:0] BSp   = 4'd4;
  localparam logic [3:0] BLv   = 4'd5;
  localparam logic [3:0] BCpp  = 4'd6;
  localparam logic [3:0] BTos  = 4'd7;
  localparam logic [3:0] BOpc  = 4'd8;

  // C bus register indices (bit of the write mask)
  localparam int CRegs = 9;
  localparam int CMar  = 0;
  localparam int CMdr  = 1;
  localparam int CPc   = 2;
  localparam int CSp   = 3;
  localparam int CLv   = 4;
  localparam int CCpp  = 5;
  localparam int CTos  = 6;
  localparam int COpc  = 7;
  localparam int CH    = 8;

  // strobes from the memory control to the datapath and the ports
  typedef struct packed {
    logic mdrFromMem;
    logic mbrFromMem;
    logic wordRd;
    logic wordWr;
    logic fetch;
  } memStrobes_t;
endpackage

// File: rtl/twoBusAlu.sv
module twoBusAlu
  import twoBusPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        ctl,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] fOut,
  output logic [DATA_W-1:0] shOut
);
  localparam int ShiftBy = 8;

  logic [DATA_W-1:0] aOp;
  logic [DATA_W-1:0] bOp;
  logic [DATA_W-1:0] leftStage;

  always_comb begin
    aOp = ctl[AluEnA] ? aIn : '0;
    if (ctl[AluInvA]) aOp = ~aOp;
    bOp = ctl[AluEnB] ? bIn : '0;
    unique case ({ctl[AluF0], ctl[AluF1]})
      2'b00:   fOut = aOp & bOp;
      2'b01:   fOut = aOp | bOp;
      2'b10:   fOut = ~bOp;
      default: fOut = aOp + bOp + {{(DATA_W-1){1'b0}}, ctl[AluInc]};
    endcase
  end

  always_comb begin
    leftStage = ctl[AluSll8] ? (fOut << ShiftBy) : fOut;
    shOut     = ctl[AluSra1] ? {leftStage[DATA_W-1], leftStage[DATA_W-1:1]} : leftStage;
  end
endmodule

// File: rtl/twoBusControl.sv
module twoBusControl
  import twoBusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  input  logic        wrReq,
  input  logic        fetchReq,
  output memStrobes_t strobes
);
  logic rdPend;
  logic wrPend;
  logic fetchPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend    <= 1'b0;
      wrPend    <= 1'b0;
      fetchPend <= 1'b0;
    end else begin
      rdPend    <= rdReq;
      wrPend    <= wrReq;
      fetchPend <= fetchReq;
    end
  end

  always_comb begin
    strobes.wordRd     = rdPend;
    strobes.mdrFromMem = rdPend;
    strobes.wordWr     = wrPend;
    strobes.fetch      = fetchPend;
    strobes.mbrFromMem = fetchPend;
  end

  assert_rd_launch_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> strobes.wordRd);
  assert_rd_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !strobes.wordRd);
  assert_wr_launch_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> strobes.wordWr);
  assert_fetch_launch_R9: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> strobes.fetch);
endmodule

// File: rtl/twoBusRegs.sv
module twoBusRegs
  import twoBusPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        aluCtl,
  input  logic [3:0]        bSel,
  input  logic [CRegs-1:0]  cMask,
  input  memStrobes_t       strobes,
  input  logic [DATA_W-1:0] wordRdData,
  input  logic [DATA_W-1:0] fetchWord,
  output logic [DATA_W-1:0] marQ,
  output logic [DATA_W-1:0] mdrQ,
  output logic [DATA_W-1:0] pcQ,
  output logic [DATA_W-1:0] cBus,
  output logic              zFlag,
  output logic              nFlag
);
  localparam int ByteW  = 8;
  localparam int Lanes  = DATA_W / ByteW;
  localparam int LaneW  = $clog2(Lanes);

  logic [DATA_W-1:0] regQ [CRegs];
  logic [ByteW-1:0]  mbrQ;
  logic [DATA_W-1:0] bBus;
  logic [DATA_W-1:0] aluF;
  logic [ByteW-1:0]  laneByte [Lanes];
  logic [ByteW-1:0]  fetchByte;

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    assign laneByte[g] = fetchWord[g*ByteW +: ByteW];
  end
  assign fetchByte = laneByte[pcQ[LaneW-1:0]];

  always_comb begin
    unique case (bSel)
      BMdr:    bBus = regQ[CMdr];
      BPc:     bBus = regQ[CPc];
      BMbrS:   bBus = {{(DATA_W-ByteW){mbrQ[ByteW-1]}}, mbrQ};
      BMbrU:   bBus = {{(DATA_W-ByteW){1'b0}}, mbrQ};
      BSp:     bBus = regQ[CSp];
      BLv:     bBus = regQ[CLv];
      BCpp:    bBus = regQ[CCpp];
      BTos:    bBus = regQ[CTos];
      BOpc:    bBus = regQ[COpc];
      default: bBus = '0;
    endcase
  end

  twoBusAlu #(.DATA_W(DATA_W)) u_alu (
    .ctl   (aluCtl),
    .aIn   (regQ[CH]),
    .bIn   (bBus),
    .fOut  (aluF),
    .shOut (cBus)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CRegs; i++) regQ[i] <= '0;
      mbrQ  <= '0;
      zFlag <= 1'b0;
      nFlag <= 1'b0;
    end else begin
      for (int i = 0; i < CRegs; i++) begin
        if (cMask[i]) regQ[i] <= cBus;
      end
      if (strobes.mdrFromMem) regQ[CMdr] <= wordRdData;
      if (strobes.mbrFromMem) mbrQ <= fetchByte;
      zFlag <= (aluF == '0);
      nFlag <= aluF[DATA_W-1];
    end
  end

  assign marQ = regQ[CMar];
  assign mdrQ = regQ[CMdr];
  assign pcQ  = regQ[CPc];

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (aluCtl == 8'h10) |=> (zFlag && !nFlag));
  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((bSel > BOpc) && (aluCtl == 8'h14)) |-> (cBus == '0));
  assert_mar_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cMask[CMar] |=> $stable(marQ));
  assert_mdr_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mdrFromMem |=> (mdrQ == $past(wordRdData)));
  assert_lane0_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mbrFromMem && (pcQ[LaneW-1:0] == '0)) |=> (mbrQ == $past(fetchWord[ByteW-1:0])));
endmodule

// File: rtl/twoBusDatapath.sv
module twoBusDatapath
  import twoBusPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        aluCtl,
  input  logic [3:0]        bSel,
  input  logic [8:0]        cMask,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              fetchReq,
  output logic [DATA_W-1:0] wordAddr,
  output logic [DATA_W-1:0] wordWrData,
  output logic              wordRdEn,
  output logic              wordWrEn,
  input  logic [DATA_W-1:0] wordRdData,
  output logic [DATA_W-1:0] fetchAddr,
  output logic              fetchEn,
  input  logic [DATA_W-1:0] fetchWord,
  output logic [DATA_W-1:0] cBus,
  output logic              zFlag,
  output logic              nFlag
);
  memStrobes_t strobes;

  twoBusControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .rdReq    (rdReq),
    .wrReq    (wrReq),
    .fetchReq (fetchReq),
    .strobes  (strobes)
  );

  twoBusRegs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .aluCtl     (aluCtl),
    .bSel       (bSel),
    .cMask      (cMask),
    .strobes    (strobes),
    .wordRdData (wordRdData),
    .fetchWord  (fetchWord),
    .marQ       (wordAddr),
    .mdrQ       (wordWrData),
    .pcQ        (fetchAddr),
    .cBus       (cBus),
    .zFlag      (zFlag),
    .nFlag      (nFlag)
  );

  assign wordRdEn = strobes.wordRd;
  assign wordWrEn = strobes.wordWr;
  assign fetchEn  = strobes.fetch;
endmodule

// File: tb/twoBusDatapath_tb.sv
module twoBusDatapath_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  aluCtl = '0;
  logic [3:0]  bSel = '0;
  logic [8:0]  cMask = '0;
  logic        rdReq = 1'b0, wrReq = 1'b0, fetchReq = 1'b0;
  logic [31:0] wordAddr, wordWrData, wordRdData, fetchAddr, fetchWord, cBus;
  logic        wordRdEn, wordWrEn, fetchEn, zFlag, nFlag;

  logic [31:0] mem [16];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign wordRdData = mem[wordAddr[3:0]];
  assign fetchWord  = mem[fetchAddr[5:2]];

  twoBusDatapath u_dut (
    .clk(clk), .rstN(rstN), .aluCtl(aluCtl), .bSel(bSel), .cMask(cMask),
    .rdReq(rdReq), .wrReq(wrReq), .fetchReq(fetchReq),
    .wordAddr(wordAddr), .wordWrData(wordWrData), .wordRdEn(wordRdEn),
    .wordWrEn(wordWrEn), .wordRdData(wordRdData), .fetchAddr(fetchAddr),
    .fetchEn(fetchEn), .fetchWord(fetchWord), .cBus(cBus),
    .zFlag(zFlag), .nFlag(nFlag)
  );

  // reference model state: index = C mask bit (0 MAR .. 8 H)
  logic [31:0] mr [9];
  logic [7:0]  mbrM;
  logic        pRd, pWr, pFe, zM, nM;

  localparam logic [8:0] MMar = 9'h001, MMdr = 9'h002, MPc = 9'h004, MSp = 9'h008,
    MLv = 9'h010, MCpp = 9'h020, MTos = 9'h040, MOpc = 9'h080, MH = 9'h100;
  localparam logic [7:0] PassB = 8'h14, PassA = 8'h18, Zero = 8'h10, BMinusA = 8'h3F,
    NegA = 8'h3B, IncB = 8'h35;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelB(input logic [3:0] b);
    case (b)
      4'd0: return mr[1];
      4'd1: return mr[2];
      4'd2: return {{24{mbrM[7]}}, mbrM};
      4'd3: return {24'h0, mbrM};
      4'd4: return mr[3];
      4'd5: return mr[4];
      4'd6: return mr[5];
      4'd7: return mr[6];
      4'd8: return mr[7];
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelAlu(input logic [7:0] ctl, input logic [31:0] h, input logic [31:0] bv,
                          output logic [31:0] f, output logic [31:0] sh);
    logic [31:0] a, b;
    a = ctl[3] ? h : 32'h0;
    if (ctl[1]) a = ~a;
    b = ctl[2] ? bv : 32'h0;
    case (ctl[5:4])
      2'b00: f = a & b;
      2'b01: f = a | b;
      2'b10: f = ~b;
      default: f = a + b + 32'(ctl[0]);
    endcase
    sh = ctl[7] ? {f[23:0], 8'h0} : f;
    if (ctl[6]) sh = {sh[31], sh[31:1]};
  endtask

  // one control word; called at a falling edge
  task automatic step(input logic [7:0] ctl, input logic [3:0] b, input logic [8:0] c,
                      input bit rd, input bit wr, input bit fe, input string tag);
    logic [31:0] f, sh, nxt [9], wrA, wrD, fw;
    logic [7:0] nMbr;
    bit wrDo;
    aluCtl = ctl; bSel = b; cMask = c; rdReq = rd; wrReq = wr; fetchReq = fe;
    #2;
    modelAlu(ctl, mr[8], modelB(b), f, sh);
    chk(tag, "cBus", cBus, sh);
    nxt = mr;
    for (int i = 0; i < 9; i++) if (c[i]) nxt[i] = sh;
    if (pRd) nxt[1] = mem[mr[0][3:0]];
    nMbr = mbrM;
    if (pFe) begin
      fw = mem[mr[2][5:2]];
      nMbr = 8'(fw >> (8 * mr[2][1:0]));
    end
    wrDo = wordWrEn; wrA = wordAddr; wrD = wordWrData;
    @(posedge clk);
    #1;
    mr = nxt; mbrM = nMbr;
    zM = (f == 32'h0); nM = f[31];
    pRd = rd; pWr = wr; pFe = fe;
    if (wrDo) mem[wrA[3:0]] = wrD;
    @(negedge clk);
    chk("R6", "zFlag", 32'(zFlag), 32'(zM));
    chk("R6", "nFlag", 32'(nFlag), 32'(nM));
    chk({"R5 ", tag}, "wordAddr", wordAddr, mr[0]);
    chk({"R5 R7 ", tag}, "wordWrData", wordWrData, mr[1]);
    chk({"R5 R9 ", tag}, "fetchAddr", fetchAddr, mr[2]);
    chk("R7", "wordRdEn", 32'(wordRdEn), 32'(pRd));
    chk("R8", "wordWrEn", 32'(wordWrEn), 32'(pWr));
    chk("R9", "fetchEn", 32'(fetchEn), 32'(pFe));
  endtask

  task automatic idle(input string tag);
    step(Zero, 4'd9, 9'h0, 0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0101_0101 * i + 32'h0300_0000;
    mem[0] = 32'h80F1_7F02;
    mem[2] = 32'hFFFF_FFF0;
    for (int i = 0; i < 9; i++) mr[i] = 32'h0;
    mbrM = 8'h0; pRd = 0; pWr = 0; pFe = 0; zM = 0; nM = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "wordAddr", wordAddr, 32'h0);
    chk("R1", "wordWrData", wordWrData, 32'h0);
    chk("R1", "fetchAddr", fetchAddr, 32'h0);
    chk("R1", "strobes", {29'h0, wordRdEn, wordWrEn, fetchEn}, 32'h0);
    chk("R1", "flags", {30'h0, zFlag, nFlag}, 32'h0);
    chk("R1", "cBus", cBus, 32'h0);
    rstN = 1'b1;

    // R7: read word 0, then observe MDR on the B bus
    step(Zero, 4'd9, 9'h0, 1, 0, 0, "R7");
    step(PassB, 4'd0, MH, 0, 0, 0, "R7");
    step(PassB, 4'd0, MH, 0, 0, 0, "R7");
    step(PassB, 4'd0, MLv, 0, 0, 0, "R7");

    // R9 R10: fetch each lane of word 0
    step(Zero, 4'd9, 9'h0, 0, 0, 1, "R9");
    idle("R9");
    step(PassB, 4'd2, MTos, 0, 0, 0, "R10");
    step(PassB, 4'd3, MOpc, 0, 0, 0, "R10");
    for (int k = 0; k < 3; k++) begin
      step(IncB, 4'd1, MPc | MMar, 0, 0, 1, "R9");
      idle("R9");
      step(PassB, 4'd2, MCpp, 0, 0, 0, "R10");
      step(PassB, 4'd3, MSp, 0, 0, 0, "R10");
    end

    // R2: ALU functions against H and several B sources
    begin
      logic [7:0] ops [12] = '{8'h0C, 8'h1C, 8'h24, 8'h3C, PassB, PassA, Zero,
                               BMinusA, NegA, IncB, 8'h39, 8'h2C};
      for (int i = 0; i < 12; i++) begin
        step(ops[i], 4'd5, 9'h0, 0, 0, 0, "R2");
        step(ops[i], 4'd6, 9'h0, 0, 0, 0, "R2");
        step(ops[i], 4'd7, 9'h0, 0, 0, 0, "R2");
      end
    end
    step(PassA, 4'd9, 9'h0, 0, 0, 0, "R6");
    step(NegA, 4'd9, 9'h0, 0, 0, 0, "R6");

    // R3: shifter on a negative and a positive value
    step(8'h94, 4'd6, 9'h0, 0, 0, 0, "R3");
    step(8'h54, 4'd6, 9'h0, 0, 0, 0, "R3");
    step(8'hD4, 4'd6, 9'h0, 0, 0, 0, "R3");
    step(8'h54, 4'd8, 9'h0, 0, 0, 0, "R3");
    step(8'h58, 4'd9, MH, 0, 0, 0, "R3");

    // R4: every B-select code
    for (int b = 0; b < 16; b++) step(PassB, 4'(b), 9'h0, 0, 0, 0, "R4");

    // R5: multi-destination write, then idle mask
    step(BMinusA, 4'd4, MSp | MCpp | MOpc, 0, 0, 0, "R5");
    step(PassB, 4'd7, 9'h0, 0, 0, 0, "R5");
    for (int b = 4; b < 9; b++) step(PassB, 4'(b), 9'h0, 0, 0, 0, "R5");

    // R8: write H to word 2 (MAR=3 after fetch loop -> set MAR=2 first)
    step(8'h36, 4'd1, MMar, 0, 0, 0, "R8");
    step(PassA, 4'd9, MMdr, 0, 1, 0, "R8");
    idle("R8");
    step(Zero, 4'd9, MMdr, 0, 0, 0, "R8");
    // R7 priority: read back while C bus also writes MDR
    step(Zero, 4'd9, 9'h0, 1, 0, 0, "R7");
    step(NegA, 4'd9, MMdr, 0, 0, 0, "R7");
    step(PassB, 4'd0, MOpc, 0, 0, 0, "R7");
    step(PassB, 4'd8, 9'h0, 0, 0, 0, "R7");
    idle("R6");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule